// File: doc/BRIEF.md
# Vector Four-Lane Group Shuffle

This unit permutes the elements of a 128-bit vector under control of an 8-bit immediate. A 2-bit format code sets the element size to 8, 16 or 32 bits. The vector is split into consecutive groups of four elements. The immediate holds four 2-bit pick fields, and each destination element takes its value from one source element of its own group. The same four picks apply to every group. Element 0 sits in the least significant bits of the vector.

A request is presented with `in_valid`. The permuted vector appears one clock later, and `out_valid` is high for that one cycle. The whole result is built from the unmodified source before it is stored, so a caller may write it back over the source register. The 64-bit format code is not a legal case for this operation. For that code the unit raises `out_illegal` and passes the source through unchanged.

A small two-state controller drives `out_valid`:
- It sits in state IDLE with `out_valid` low.
- Transition LOAD_T moves it to state LOAD on any cycle where `in_valid` is high.
- It stays in LOAD while requests arrive back to back.
- Transition DRAIN_T returns it to IDLE when `in_valid` is low.

Top module: `vgrp_shuffle`

## Requirements
- R1: The format code is 0 for 8-bit, 1 for 16-bit, 2 for 32-bit and 3 for 64-bit elements. Element k occupies bits [k*W +: W] of the vector, where W is the element width.
- R2: With format 0, destination byte i equals source byte (i & ~3) + ((imm >> 2*(i%4)) & 3), for all 16 bytes.
- R3: With format 1, the same selection rule applies to the 8 halfwords.
- R4: With format 2, the same selection rule applies to the 4 words.
- R5: With format 3, the captured output equals the source vector and `out_illegal` is 1.
- R6: With formats 0, 1 or 2, `out_illegal` is 0 in the result cycle.
- R7: When `in_valid` is high at a rising edge, the result appears after that edge, and `out_valid` is high for exactly the following cycle.
- R8: A cycle with `in_valid` low leaves `out_data` and `out_illegal` unchanged and drives `out_valid` low, whatever the other inputs are.
- R9: While `rst_n` is low, `out_valid`, `out_illegal` and `out_data` are all zero.
- R10: Immediate 0xE4 (picks 0,1,2,3) returns the source unchanged in every legal format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_fmt | input | 2 | Element format code |
| in_imm | input | 8 | Four packed 2-bit pick fields |
| in_data | input | 128 | Source vector |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_illegal | output | 1 | Format 3 was requested |
| out_data | output | 128 | Permuted vector |

## Verification
The assertions check the timing and flag behaviour on every cycle:
- A request is followed by exactly one valid cycle.
- An idle cycle leaves the stored result and flag stable.
- Format 3 passes the source through with the flag set, and legal formats clear the flag.

The element mapping itself is shown only by the bench. It sweeps all 256 immediates in each legal format over distinct-valued data patterns and compares every element against the selection rule, which it computes itself.

// File: rtl/vgrp_pkg.sv
package vgrp_pkg;
    typedef enum logic [1:0] {
        FMT_B8  = 2'd0,
        FMT_H16 = 2'd1,
        FMT_W32 = 2'd2,
        FMT_D64 = 2'd3
    } vfmt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOAD = 1'b1
    } vstate_e;

    localparam int GROUP_N   = 4;
    localparam int PICK_W    = 2;
    localparam int IMM_W     = GROUP_N * PICK_W;
    localparam int LEGAL_FMT = 3;
endpackage

// File: rtl/vgrp_perm.sv
module vgrp_perm #(
    parameter int VEC_W  = 128,
    parameter int ELEM_W = 8
) (
    input  logic [VEC_W-1:0]          src,
    input  logic [vgrp_pkg::IMM_W-1:0] imm,
    output logic [VEC_W-1:0]          dst
);
    localparam int N  = VEC_W / ELEM_W;
    localparam int IW = $clog2(N);

    logic [ELEM_W-1:0] el [N];

    for (genvar g = 0; g < N; g++) begin : g_split
        assign el[g] = src[g*ELEM_W +: ELEM_W];
    end

    for (genvar i = 0; i < N; i++) begin : g_pick
        localparam int BASE = (i / vgrp_pkg::GROUP_N) * vgrp_pkg::GROUP_N;
        localparam int SH   = vgrp_pkg::PICK_W * (i % vgrp_pkg::GROUP_N);
        logic [vgrp_pkg::PICK_W-1:0] sel;
        logic [IW-1:0]               idx;
        assign sel = imm[SH +: vgrp_pkg::PICK_W];
        assign idx = IW'(BASE) + IW'(sel);
        assign dst[i*ELEM_W +: ELEM_W] = el[idx];
    end
endmodule

// File: rtl/vgrp_shuffle.sv
module vgrp_shuffle #(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_fmt,
    input  logic [7:0]       in_imm,
    input  logic [VEC_W-1:0] in_data,
    output logic             out_valid,
    output logic             out_illegal,
    output logic [VEC_W-1:0] out_data
);
    import vgrp_pkg::*;

    logic [VEC_W-1:0] perm [LEGAL_FMT];

    for (genvar f = 0; f < LEGAL_FMT; f++) begin : g_fmt
        vgrp_perm #(.VEC_W(VEC_W), .ELEM_W(8 << f)) u_perm (
            .src (in_data),
            .imm (in_imm),
            .dst (perm[f])
        );
    end

    vfmt_e            fmt;
    logic             illegal_d;
    logic [VEC_W-1:0] data_d;

    always_comb begin
        fmt       = vfmt_e'(in_fmt);
        illegal_d = 1'b0;
        data_d    = in_data;
        unique case (fmt)
            FMT_B8:  data_d = perm[0];
            FMT_H16: data_d = perm[1];
            FMT_W32: data_d = perm[2];
            FMT_D64: illegal_d = 1'b1;
        endcase
    end

    vstate_e st_q, st_d;

    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = in_valid ? ST_LOAD : ST_IDLE;
            ST_LOAD: st_d = in_valid ? ST_LOAD : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_illegal <= 1'b0;
            out_data    <= '0;
        end else if (in_valid) begin
            out_illegal <= illegal_d;
            out_data    <= data_d;
        end
    end

    assign out_valid = (st_q == ST_LOAD);

    // R7
    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R8
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_illegal)));
    // R5
    p_illegal_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt == 2'd3) |=> (out_illegal && out_data == $past(in_data)));
    // R6
    p_legal_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt != 2'd3) |=> !out_illegal);
endmodule

// File: tb/sim_vgrp_shuffle.sv
module sim_vgrp_shuffle;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   in_fmt = 2'd0;
    logic [7:0]   in_imm = 8'd0;
    logic [127:0] in_data = '0;
    logic         out_valid, out_illegal;
    logic [127:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vgrp_shuffle u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
        .in_imm(in_imm), .in_data(in_data), .out_valid(out_valid),
        .out_illegal(out_illegal), .out_data(out_data)
    );

    function automatic logic [127:0] pattern(input int seed);
        logic [127:0] v;
        for (int k = 0; k < 16; k++) v[k*8 +: 8] = 8'((k * 37 + seed * 11 + 5) & 255);
        return v;
    endfunction

    function automatic logic [127:0] expect_perm(input logic [127:0] s, input int f, input logic [7:0] imm);
        logic [127:0] r;
        int w, n, j;
        r = s;
        if (f == 3) return s;
        w = 8 << f;
        n = 128 / w;
        for (int i = 0; i < n; i++) begin
            j = (i & ~3) + ((imm >> (2 * (i % 4))) & 3);
            for (int b = 0; b < w; b++) r[i*w + b] = s[j*w + b];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [128:0] act, input logic [128:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input int f, input logic [7:0] imm, input logic [127:0] d, input string req);
        logic [127:0] e;
        @(negedge clk);
        in_valid = 1'b1; in_fmt = 2'(f); in_imm = imm; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
        e = expect_perm(d, f, imm);
        check({req, " data/flag"}, {out_illegal, out_data}, {(f == 3), e});
        check("R7 valid", {128'd0, out_valid}, 129'd1);
    endtask

    initial begin
        logic [127:0] d;
        logic [127:0] keep;
        repeat (3) @(negedge clk);
        check("R9 reset", {out_illegal, out_data}, 129'd0);
        check("R9 reset valid", {128'd0, out_valid}, 129'd0);
        @(negedge clk); rst_n = 1'b1;
        // R2 R3 R4 exhaustive over the immediate
        for (int f = 0; f < 3; f++) begin
            for (int s = 0; s < 2; s++) begin
                for (int im = 0; im < 256; im++) begin
                    d = pattern(s * 300 + im);
                    issue(f, 8'(im), d, f == 0 ? "R2 byte" : (f == 1 ? "R3 half" : "R4 word"));
                end
            end
        end
        // R1 element 0 at LSB: broadcast element 0 with imm 0
        d = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
        issue(0, 8'h00, d, "R1 byte lsb");
        check("R1 byte broadcast", {1'b0, out_data}, {1'b0, 128'h0c0c0c0c_08080808_04040404_00000000});
        issue(2, 8'hFF, d, "R1 word top");
        check("R1 word broadcast", {1'b0, out_data}, {1'b0, {4{32'h0f0e0d0c}}});
        // R10 identity
        for (int f = 0; f < 3; f++) begin
            issue(f, 8'hE4, d, "R10 identity");
            check("R10 identity src", {1'b0, out_data}, {1'b0, d});
        end
        // R5 illegal
        for (int im = 0; im < 8; im++) issue(3, 8'(im * 31), pattern(im), "R5 illegal");
        // R6 flag clears after illegal
        issue(1, 8'h1B, d, "R6 legal after illegal");
        check("R6 flag", {128'd0, out_illegal}, 129'd0);
        // R8 idle inputs changing do not disturb
        keep = out_data;
        @(negedge clk);
        in_fmt = 2'd3; in_imm = 8'h55; in_data = ~d;
        @(negedge clk);
        check("R8 hold", {out_illegal, out_data}, {1'b0, keep});
        check("R8 valid low", {128'd0, out_valid}, 129'd0);
        // R7 back to back
        @(negedge clk);
        in_valid = 1'b1; in_fmt = 2'd0; in_imm = 8'h1B; in_data = d;
        @(negedge clk);
        check("R7 b2b first", {out_illegal, out_data}, {1'b0, expect_perm(d, 0, 8'h1B)});
        in_fmt = 2'd2;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 b2b second", {out_illegal, out_data}, {1'b0, expect_perm(d, 2, 8'h1B)});
        check("R7 b2b valid", {128'd0, out_valid}, 129'd1);
        @(negedge clk);
        check("R7 single pulse", {128'd0, out_valid}, 129'd0);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule